// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the first status register of a serial NOR flash device and decides, instruction by instruction, whether the device acts on what the SPI front end has decoded. The front end presents one decoded instruction per strobe, together with the data byte for a status write and the level of the write-protect pin. The block keeps the write-enable latch, the busy flag and six protection bits. It returns the assembled 8-bit status byte and raises a one-cycle accepted or ignored pulse for every strobe.

Program, erase, status-write and security-register operations need a prior write enable. They clear the write-enable latch and hold the busy flag for a fixed number of clock cycles, one parameter per operation class, standing in for the array's real timing. While busy is set, the block takes only status reads and suspend requests.

Top module: `flash_sr_ctrl`

## Requirements
- R1: After reset, and after any reset that comes while an operation is running, the status byte is 0x00 and both pulse outputs are low.
- R2: Instruction code 1 (write enable) sets the write-enable bit (status bit 1) when busy is clear, and code 2 (write disable) clears it.
- R3: Codes 3 (page program), 4 (quad page program), 5 (sector erase), 6 (block erase), 7 (chip erase), 9 (security erase) and 10 (security program) are accepted only when the write-enable bit is 1. They clear the write-enable bit and set busy (status bit 0).
- R4: Busy stays at 1 for exactly the cycle count of the accepted class, counted from the accepting edge: PROG_CYC for codes 3 and 4, SECT_CYC, BLK_CYC and CHIP_CYC for codes 5, 6 and 7, SECR_CYC for codes 9 and 10, and WRSR_CYC for code 8.
- R5: A program, erase or status-write instruction that arrives while the write-enable bit is 0 is ignored and changes no status bit.
- R6: While busy is 1, every instruction is ignored except code 11 (read status) and code 12 (suspend). Those two are always accepted and change no status bit.
- R7: An accepted code 8 (write status) loads data bits 7..2 into status bits 7..2 (SRP0, SEC, TB, BP2, BP1, BP0). Data bits 1..0 are discarded.
- R8: A write status that arrives while SRP0 (status bit 7) is 1 and wp_n is 0 is ignored and leaves bits 7..2 unchanged, but it clears the write-enable bit. With wp_n at 1 the same write is accepted.
- R9: Each strobe produces exactly one of cmd_accept or cmd_ignore, high for one cycle on the cycle after the strobe. Both are low when there is no strobe, and unused codes (0, 13 to 15) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe of a decoded instruction |
| cmd_code | input | 4 | Decoded instruction code |
| wr_data | input | 8 | Data byte of a write status instruction |
| wp_n | input | 1 | Write-protect pin level, active low |
| status_byte | output | 8 | {SRP0, SEC, TB, BP2, BP1, BP0, WEL, BUSY} |
| cmd_accept | output | 1 | Pulse: previous strobe was acted on |
| cmd_ignore | output | 1 | Pulse: previous strobe was rejected |

## Verification
The hardest state to reach is a hardware-locked status write. It needs an earlier accepted write that set SRP0, then a wait for that write's busy time to end, then a fresh write enable, and only then a write status with wp_n driven low. The stimulus table strings those steps together in order. It then checks that the locked write is ignored while the write-enable bit still drops, and that a later write with wp_n high clears the lock. The busy-gating cases are reached by issuing a chip erase, whose busy time is long, and sending several instructions of different kinds inside that window.

// File: rtl/flash_sr_pkg.sv
// Package: instruction codes, operation classes and helpers shared by
// the status register controller, its submodules and its checker.
package flash_sr_pkg;

    typedef enum logic [3:0] {
        CMD_NONE  = 4'd0,
        CMD_WREN  = 4'd1,
        CMD_WRDI  = 4'd2,
        CMD_PROG  = 4'd3,
        CMD_QPROG = 4'd4,
        CMD_SECT  = 4'd5,
        CMD_BLK   = 4'd6,
        CMD_CHIP  = 4'd7,
        CMD_WRSR  = 4'd8,
        CMD_SERA  = 4'd9,
        CMD_SPRG  = 4'd10,
        CMD_RDSR  = 4'd11,
        CMD_SUSP  = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        CLS_PROG = 3'd0,
        CLS_SECT = 3'd1,
        CLS_BLK  = 3'd2,
        CLS_CHIP = 3'd3,
        CLS_WRSR = 3'd4,
        CLS_SECR = 3'd5
    } op_cls_e;

    localparam int NUM_CLS  = 6;
    localparam int PROT_W   = 6;

    // True for every instruction that needs write enable and starts busy.
    function automatic logic needs_wel(input logic [3:0] code);
        case (code)
            CMD_PROG, CMD_QPROG, CMD_SECT, CMD_BLK, CMD_CHIP,
            CMD_WRSR, CMD_SERA, CMD_SPRG: needs_wel = 1'b1;
            default:                      needs_wel = 1'b0;
        endcase
    endfunction

    // True for instructions that pass the busy gate.
    function automatic logic busy_exempt(input logic [3:0] code);
        busy_exempt = (code == CMD_RDSR) || (code == CMD_SUSP);
    endfunction

endpackage

// File: rtl/sr_cmd_gate.sv
// Command gate: purely combinational decision on one strobe.
// Assumes busy, wel and srp0 are the registered current state.
// Produces the accept decision, the state-change requests and the
// operation class whose busy count must be loaded.
module sr_cmd_gate
    import flash_sr_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_code,
    input  logic        busy,
    input  logic        wel,
    input  logic        srp0,
    input  logic        wp_n,
    output logic        accept,
    output logic        set_wel,
    output logic        clr_wel,
    output logic        load_prot,
    output logic        start_op,
    output op_cls_e     op_cls
);

    logic hw_locked;

    // Status write is blocked by the hardware pin when SRP0 is set.
    assign hw_locked = srp0 && !wp_n;

    // Decide acceptance and the state updates for the current strobe.
    always_comb begin
        accept    = 1'b0;
        set_wel   = 1'b0;
        clr_wel   = 1'b0;
        load_prot = 1'b0;
        start_op  = 1'b0;
        op_cls    = CLS_PROG;
        if (cmd_valid) begin
            if (busy) begin
                accept = busy_exempt(cmd_code);
            end else begin
                case (cmd_e'(cmd_code))
                    CMD_WREN: begin
                        accept  = 1'b1;
                        set_wel = 1'b1;
                    end
                    CMD_WRDI: begin
                        accept  = 1'b1;
                        clr_wel = 1'b1;
                    end
                    CMD_RDSR, CMD_SUSP: accept = 1'b1;
                    CMD_WRSR: begin
                        op_cls = CLS_WRSR;
                        if (wel) begin
                            clr_wel = 1'b1;
                            if (!hw_locked) begin
                                accept    = 1'b1;
                                load_prot = 1'b1;
                                start_op  = 1'b1;
                            end
                        end
                    end
                    CMD_PROG, CMD_QPROG, CMD_SECT, CMD_BLK, CMD_CHIP,
                    CMD_SERA, CMD_SPRG: begin
                        case (cmd_e'(cmd_code))
                            CMD_SECT:          op_cls = CLS_SECT;
                            CMD_BLK:           op_cls = CLS_BLK;
                            CMD_CHIP:          op_cls = CLS_CHIP;
                            CMD_SERA, CMD_SPRG: op_cls = CLS_SECR;
                            default:           op_cls = CLS_PROG;
                        endcase
                        if (wel) begin
                            accept   = 1'b1;
                            clr_wel  = 1'b1;
                            start_op = 1'b1;
                        end
                    end
                    default: accept = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/sr_busy_timer.sv
// Busy timer: a down-counter loaded with the cycle count of the started
// operation class. Busy is high while the count is non-zero, so it lasts
// exactly the class count from the loading edge. Assumes start is only
// raised while the counter is idle.
module sr_busy_timer
    import flash_sr_pkg::*;
#(
    parameter int PROG_CYC = 12,
    parameter int SECT_CYC = 24,
    parameter int BLK_CYC  = 40,
    parameter int CHIP_CYC = 96,
    parameter int WRSR_CYC = 8,
    parameter int SECR_CYC = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  op_cls_e cls,
    output logic    busy
);

    localparam int M01   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int M23   = (BLK_CYC  > CHIP_CYC) ? BLK_CYC  : CHIP_CYC;
    localparam int M45   = (WRSR_CYC > SECR_CYC) ? WRSR_CYC : SECR_CYC;
    localparam int M0123 = (M01 > M23) ? M01 : M23;
    localparam int MAXC  = (M0123 > M45) ? M0123 : M45;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int CYC [NUM_CLS] = '{PROG_CYC, SECT_CYC, BLK_CYC,
                                      CHIP_CYC, WRSR_CYC, SECR_CYC};

    logic [CNT_W-1:0] dur_tab [NUM_CLS];
    logic [CNT_W-1:0] cnt_q;

    // Build the per-class duration table at the counter width.
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_dur
        assign dur_tab[g] = CNT_W'(CYC[g]);
    end

    // Load on start, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= dur_tab[cls];
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/sr_status_regs.sv
// Status storage: the write-enable latch and the six writable protection
// bits (SRP0, SEC, TB, BP2..BP0). Clear of the latch wins over set; the
// gate never asks for both in one cycle.
module sr_status_regs
    import flash_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              load_prot,
    input  logic [PROT_W-1:0] prot_din,
    output logic              wel,
    output logic [PROT_W-1:0] prot
);

    // Write-enable latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (clr_wel) begin
            wel <= 1'b0;
        end else if (set_wel) begin
            wel <= 1'b1;
        end
    end

    // Protection bits load from an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= '0;
        end else if (load_prot) begin
            prot <= prot_din;
        end
    end

endmodule

// File: rtl/flash_sr_ctrl.sv
// Top: status register controller of a serial NOR flash. Takes decoded
// instruction strobes, gates them on busy / write-enable / hardware lock,
// runs the busy countdown, and returns the status byte
// {SRP0,SEC,TB,BP2,BP1,BP0,WEL,BUSY} plus one accept/ignore pulse per
// strobe, registered one cycle after it. Assumes strobes are one cycle.
module flash_sr_ctrl
    import flash_sr_pkg::*;
#(
    parameter int PROG_CYC = 12,
    parameter int SECT_CYC = 24,
    parameter int BLK_CYC  = 40,
    parameter int CHIP_CYC = 96,
    parameter int WRSR_CYC = 8,
    parameter int SECR_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    output logic [7:0] status_byte,
    output logic       cmd_accept,
    output logic       cmd_ignore
);

    logic              busy;
    logic              wel;
    logic [PROT_W-1:0] prot;
    logic              accept;
    logic              set_wel;
    logic              clr_wel;
    logic              load_prot;
    logic              start_op;
    op_cls_e           op_cls;

    sr_cmd_gate u_gate (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .busy      (busy),
        .wel       (wel),
        .srp0      (prot[PROT_W-1]),
        .wp_n      (wp_n),
        .accept    (accept),
        .set_wel   (set_wel),
        .clr_wel   (clr_wel),
        .load_prot (load_prot),
        .start_op  (start_op),
        .op_cls    (op_cls)
    );

    sr_busy_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLK_CYC  (BLK_CYC),
        .CHIP_CYC (CHIP_CYC),
        .WRSR_CYC (WRSR_CYC),
        .SECR_CYC (SECR_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_op),
        .cls   (op_cls),
        .busy  (busy)
    );

    sr_status_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wel   (set_wel),
        .clr_wel   (clr_wel),
        .load_prot (load_prot),
        .prot_din  (wr_data[7:2]),
        .wel       (wel),
        .prot      (prot)
    );

    // Register the per-strobe outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_ignore <= 1'b0;
        end else begin
            cmd_accept <= cmd_valid && accept;
            cmd_ignore <= cmd_valid && !accept;
        end
    end

    assign status_byte = {prot, wel, busy};

endmodule

// File: rtl/flash_sr_ctrl_chk.sv
// Checker: temporal properties of the controller, seen at its ports.
module flash_sr_ctrl_chk
    import flash_sr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic       wp_n,
    input logic [7:0] status_byte,
    input logic       cmd_accept,
    input logic       cmd_ignore
);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_ignore));

    // R9
    pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_accept || cmd_ignore));

    // R9
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(cmd_accept || cmd_ignore));

    // R6
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && status_byte[0] && !busy_exempt(cmd_code))
        |=> cmd_ignore);

    // R6
    busy_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy_exempt(cmd_code))
        |=> (cmd_accept && status_byte[7:1] == $past(status_byte[7:1])));

    // R5
    no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !status_byte[0] && !status_byte[1] && needs_wel(cmd_code))
        |=> (cmd_ignore && status_byte == $past(status_byte)));

    // R2
    wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !status_byte[0] && cmd_code == CMD_WREN)
        |=> status_byte[1]);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[0]) |-> !status_byte[1]);

    // R8
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !status_byte[0] && status_byte[7] && !wp_n
         && cmd_code == CMD_WRSR)
        |=> (cmd_ignore && !status_byte[1]
             && status_byte[7:2] == $past(status_byte[7:2])));

endmodule

bind flash_sr_ctrl flash_sr_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .wp_n        (wp_n),
    .status_byte (status_byte),
    .cmd_accept  (cmd_accept),
    .cmd_ignore  (cmd_ignore)
);

// File: tb/flash_sr_ctrl_tb.sv
`timescale 1ns/1ps
module flash_sr_ctrl_tb;

    localparam int PROG_CYC = 12;
    localparam int SECT_CYC = 24;
    localparam int BLK_CYC  = 40;
    localparam int CHIP_CYC = 96;
    localparam int WRSR_CYC = 8;
    localparam int SECR_CYC = 16;

    typedef struct packed {
        logic [3:0] code;
        logic [7:0] data;
        logic       wp;
        logic       acc;
        logic [7:0] st;
        logic       settle;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd11, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 read status idle
        '{4'd3,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 program without WEL
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b0, 4'd2},  // R2 write enable
        '{4'd2,  8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 4'd2},  // R2 write disable
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b0, 4'd2},
        '{4'd5,  8'h00, 1'b1, 1'b1, 8'h01, 1'b1, 4'd3},  // R3 sector erase
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b0, 4'd2},
        '{4'd8,  8'hFF, 1'b1, 1'b1, 8'hFD, 1'b1, 4'd7},  // R7 low bits dropped
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'hFE, 1'b0, 4'd2},
        '{4'd8,  8'h00, 1'b0, 1'b0, 8'hFC, 1'b0, 4'd8},  // R8 locked, WEL cleared
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'hFE, 1'b0, 4'd2},
        '{4'd8,  8'h03, 1'b1, 1'b1, 8'h01, 1'b1, 4'd8},  // R8 pin high unlocks
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b0, 4'd2},
        '{4'd7,  8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 4'd3},  // R3 chip erase
        '{4'd1,  8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 4'd6},  // R6 WREN while busy
        '{4'd11, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 4'd6},  // R6 read while busy
        '{4'd12, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 4'd6},  // R6 suspend while busy
        '{4'd8,  8'hFC, 1'b1, 1'b0, 8'h01, 1'b0, 4'd6},  // R6 WRSR while busy
        '{4'd15, 8'h00, 1'b1, 1'b0, 8'h01, 1'b1, 4'd9},  // R9 unused code
        '{4'd0,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 code zero
        '{4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b0, 4'd2},
        '{4'd10, 8'h00, 1'b1, 1'b1, 8'h01, 1'b1, 4'd3},  // R3 security program
        '{4'd4,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd5}   // R5 quad program, WEL 0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = '0;
    logic [7:0] wr_data = '0;
    logic       wp_n = 1'b1;
    logic [7:0] status_byte;
    logic       cmd_accept;
    logic       cmd_ignore;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_sr_ctrl #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLK_CYC  (BLK_CYC),
        .CHIP_CYC (CHIP_CYC),
        .WRSR_CYC (WRSR_CYC),
        .SECR_CYC (SECR_CYC)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .wr_data     (wr_data),
        .wp_n        (wp_n),
        .status_byte (status_byte),
        .cmd_accept  (cmd_accept),
        .cmd_ignore  (cmd_ignore)
    );

    task automatic chk(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge; return at the falling edge after
    // the accepting rising edge, where the result is visible.
    task automatic issue(input logic [3:0] code, input logic [7:0] data,
                         input logic wp);
        cmd_valid = 1'b1;
        cmd_code  = code;
        wr_data   = data;
        wp_n      = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 400 && status_byte[0]; i++) @(negedge clk);
        chk("R4 busy ends", {7'd0, status_byte[0]}, 8'h00);
    endtask

    // Check the exact busy length of one class.
    task automatic dur_check(input logic [3:0] code, input int cyc,
                             input string req);
        issue(4'd1, 8'h00, 1'b1);
        issue(code, 8'h00, 1'b1);
        repeat (cyc - 1) @(negedge clk);
        chk(req, {7'd0, status_byte[0]}, 8'h01);
        @(negedge clk);
        chk(req, {7'd0, status_byte[0]}, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status_byte, 8'h00);
        chk("R1 pulses", {6'd0, cmd_accept, cmd_ignore}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            issue(VEC[v].code, VEC[v].data, VEC[v].wp);
            chk($sformatf("R%0d vec%0d pulse", VEC[v].req, v),
                {6'd0, cmd_accept, cmd_ignore},
                {6'd0, VEC[v].acc, !VEC[v].acc});
            chk($sformatf("R%0d vec%0d status", VEC[v].req, v),
                status_byte, VEC[v].st);
            if (VEC[v].settle) settle();
        end

        // R9 pulse lasts a single cycle
        issue(4'd11, 8'h00, 1'b1);
        @(negedge clk);
        chk("R9 single cycle", {6'd0, cmd_accept, cmd_ignore}, 8'h00);

        // R4 exact busy length per class
        dur_check(4'd3, PROG_CYC, "R4 page program");
        dur_check(4'd4, PROG_CYC, "R4 quad program");
        dur_check(4'd5, SECT_CYC, "R4 sector erase");
        dur_check(4'd6, BLK_CYC,  "R4 block erase");
        dur_check(4'd7, CHIP_CYC, "R4 chip erase");
        dur_check(4'd9, SECR_CYC, "R4 security erase");
        dur_check(4'd8, WRSR_CYC, "R4 write status");

        // R7 partial pattern lands on bits 7..2 only
        issue(4'd1, 8'h00, 1'b1);
        issue(4'd8, 8'h56, 1'b1);
        settle();
        chk("R7 pattern", status_byte, 8'h54);

        // R1 reset during a running operation
        issue(4'd1, 8'h00, 1'b1);
        issue(4'd7, 8'h00, 1'b1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-op reset", status_byte, 8'h00);
        chk("R1 mid-op pulses", {6'd0, cmd_accept, cmd_ignore}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", status_byte, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule